// File: doc/BRIEF.md
# Sleep Wake-Up Source Controller

This block sits in a power manager and decides when a sleeping system should wake. It keeps two software-visible registers: a wake-source enable mask and a five-bit clock speed setting for the core PLL. It watches a bank of general-purpose pins and an RTC alarm pulse. While the sleep input is high, it turns any qualified event into a one-cycle wake request.

A pin event is any change of level, rising or falling. It counts only when the pin's enable bit is set and the pin is configured as an input. The RTC alarm counts when its own enable bit is set. Either supply fault pin forces the enable mask back to its hard-reset value, which leaves only pins 0 and 1 armed. The clock speed setting holds its value through sleep and through faults, and only a hard reset clears it.

Registers are reached through a simple bus. A write is taken on the clock edge where the strobe is high. Reads are combinational on the address.

Top module: `wake_src_ctrl`

## Requirements
- R1: After hard reset the enable mask reads 0x00000003, the clock setting reads 0, `clk_cfg` is 0 and `wake_req` is low.
- R2: A write to offset 0x0C stores the enable mask. Bits 0..27 enable pins 0..27 and bit 31 enables the RTC alarm. Bits 28..30 ignore writes and read as zero, so writing 0xFFFFFFFF reads back 0x8FFFFFFF.
- R3: A write to offset 0x14 stores `wdata[4:0]` as the clock setting, which then appears on `clk_cfg`. Reads of offset 0x14 return zero in bits 31..5, and reads of any unmapped offset return 0.
- R4: When `vdd_fault` or `batt_fault` is high at a clock edge, the enable mask becomes 0x00000003 at that edge. This holds even if a bus write to offset 0x0C happens in the same cycle.
- R5: A rising or falling change on pin n, with mask bit n set and `gpio_dir[n]`=0 (input), gives exactly one `wake_req` pulse while asleep. The pulse is high in the second cycle after the change is applied.
- R6: A change on a pin whose mask bit is clear, or whose `gpio_dir` bit is 1 (output), gives no `wake_req`.
- R7: `rtc_alarm` high for one cycle with mask bit 31 set gives a one-cycle `wake_req` in the next cycle. With bit 31 clear it gives none.
- R8: `wake_req` never rises while `asleep` is low.
- R9: Faults and sleep leave the clock setting unchanged. Only hard reset clears it.
- R10: Pins held high through reset produce no wake request when reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, active low, asynchronous |
| vdd_fault | input | 1 | Core supply fault, active high |
| batt_fault | input | 1 | Battery fault, active high |
| asleep | input | 1 | High while the system is in sleep |
| gpio_in | input | 28 | General-purpose pin levels |
| gpio_dir | input | 28 | Pin direction, 1 = output, 0 = input |
| rtc_alarm | input | 1 | RTC alarm pulse |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| clk_cfg | output | 5 | Stored clock speed setting |
| wake_req | output | 1 | One-cycle wake request |

## Verification
The bench fires a fault in the same cycle as a mask write. A design that gives the bus priority would keep the written mask and leave extra pins armed through a brownout. It toggles pins in both directions, on outputs, on disabled bits and while awake, and it counts every `wake_req` cycle within a window. This catches a detector that only sees rising edges, a missing direction check, and stretched or early pulses. It holds every pin high across reset, which exposes a detector whose previous-sample register starts at zero and reports a false edge. It also reads the clock setting after faults and checks that a hard reset clears it.

// File: rtl/wake_src_ctrl.sv
module wake_src_ctrl #(
  parameter int NGPIO  = 28,
  parameter int ADDR_W = 8,
  parameter int CFG_W  = 5,
  parameter logic [ADDR_W-1:0] EN_OFS  = 8'h0C,
  parameter logic [ADDR_W-1:0] CFG_OFS = 8'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vdd_fault,
  input  logic              batt_fault,
  input  logic              asleep,
  input  logic [NGPIO-1:0]  gpio_in,
  input  logic [NGPIO-1:0]  gpio_dir,
  input  logic              rtc_alarm,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [CFG_W-1:0]  clk_cfg,
  output logic              wake_req
);
  localparam logic [31:0] EN_MASK  = 32'h8000_0000 | ((32'd1 << NGPIO) - 32'd1);
  localparam logic [31:0] EN_RESET = 32'h0000_0003;
  localparam int RTC_BIT = 31;

  logic [31:0]      en_q;
  logic [CFG_W-1:0] cfg_q;
  logic [NGPIO-1:0] smp_q, prv_q;
  logic [1:0]       arm_q;
  logic             fault;
  logic [NGPIO-1:0] pin_hit;
  logic             hit;

  assign fault = vdd_fault | batt_fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= EN_RESET;
      cfg_q <= '0;
    end else begin
      if (fault)
        en_q <= EN_RESET;
      else if (bus_wr && bus_addr == EN_OFS)
        en_q <= bus_wdata & EN_MASK;
      if (bus_wr && bus_addr == CFG_OFS)
        cfg_q <= bus_wdata[CFG_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= '0;
      prv_q <= '0;
      arm_q <= '0;
    end else begin
      smp_q <= gpio_in;
      prv_q <= smp_q;
      arm_q <= {arm_q[0], 1'b1};
    end
  end

  assign pin_hit = (smp_q ^ prv_q) & en_q[NGPIO-1:0] & ~gpio_dir & {NGPIO{arm_q[1]}};
  assign hit     = (|pin_hit) | (rtc_alarm & en_q[RTC_BIT]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_req <= 1'b0;
    else        wake_req <= asleep & hit;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == EN_OFS)       bus_rdata = en_q;
    else if (bus_addr == CFG_OFS) bus_rdata[CFG_W-1:0] = cfg_q;
  end

  assign clk_cfg = cfg_q;

  AST_FAULT_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> bus_rdata == EN_RESET || bus_addr != EN_OFS);  // R4
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == EN_OFS |-> (bus_rdata & ~EN_MASK) == 32'd0);  // R2
  AST_NO_WAKE_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !asleep |=> !wake_req);  // R8
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == CFG_OFS) |=> $stable(clk_cfg));  // R9
  AST_RTC_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && rtc_alarm && en_q[RTC_BIT]) |=> wake_req);  // R7
endmodule

// File: tb/wake_src_ctrl_tb.sv
module wake_src_ctrl_tb;
  logic clk = 0, rst_n = 0;
  logic vdd_fault = 0, batt_fault = 0, asleep = 0, rtc_alarm = 0;
  logic [27:0] gpio_in = '0, gpio_dir = '0;
  logic bus_wr = 0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [4:0] clk_cfg;
  logic wake_req;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  wake_src_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .vdd_fault(vdd_fault), .batt_fault(batt_fault),
    .asleep(asleep), .gpio_in(gpio_in), .gpio_dir(gpio_dir), .rtc_alarm(rtc_alarm),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .clk_cfg(clk_cfg), .wake_req(wake_req));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic watch(input int n, output int cnt, output int first);
    cnt = 0; first = -1;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (wake_req) begin cnt++; if (first < 0) first = i; end
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    int cnt, first;
    asleep = 1; gpio_in = '1;
    repeat (2) @(negedge clk);
    rst_n = 1;
    check("R1 wake_req at reset", wake_req, 0);
    check("R1 clk_cfg at reset", clk_cfg, 0);
    rd(8'h0C, d); check("R1 enable mask reset", d, 32'h3);
    rd(8'h14, d); check("R1 clock setting reset", d, 0);
    watch(5, cnt, first);
    check("R10 no wake from pins high at reset", cnt, 0);
    asleep = 0; gpio_in = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, d); check("R2 reserved bits dropped", d, 32'h8FFF_FFFF);
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, d); check("R3 clock setting readback", d, 32'h1F);
    check("R3 clk_cfg output", clk_cfg, 5'h1F);
    rd(8'h10, d); check("R3 unmapped offset reads zero", d, 0);
  endtask

  task automatic t_fault;
    logic [31:0] d;
    wr(8'h0C, 32'h1234_5678);
    rd(8'h0C, d); check("R2 mask write", d, 32'h0234_5678);
    vdd_fault = 1; @(negedge clk); vdd_fault = 0;
    rd(8'h0C, d); check("R4 vdd fault forces mask", d, 32'h3);
    batt_fault = 1; wr(8'h0C, 32'hFFFF_0000); batt_fault = 0;
    rd(8'h0C, d); check("R4 fault wins over write", d, 32'h3);
    check("R9 clock setting kept through fault", clk_cfg, 5'h1F);
  endtask

  task automatic toggle(input int idx, input string tag, input int exp_cnt);
    int cnt, first;
    gpio_in[idx] = ~gpio_in[idx];
    watch(5, cnt, first);
    check({tag, " count"}, cnt, exp_cnt);
    if (exp_cnt == 1) check({tag, " timing"}, first, 2);
  endtask

  task automatic t_gpio;
    wr(8'h0C, 32'h0800_0020);
    gpio_dir = '0; asleep = 1;
    @(negedge clk);
    toggle(5, "R5 rising edge pin5", 1);
    toggle(5, "R5 falling edge pin5", 1);
    toggle(27, "R5 rising edge pin27", 1);
    toggle(4, "R6 disabled pin4", 0);
    gpio_dir[5] = 1;
    toggle(5, "R6 output pin5", 0);
    gpio_dir[5] = 0;
    asleep = 0;
    toggle(27, "R8 pin27 while awake", 0);
  endtask

  task automatic rtc_shot(input string tag, input int exp_cnt);
    int cnt, first, c0;
    rtc_alarm = 1;
    @(negedge clk);
    c0 = wake_req ? 1 : 0;
    rtc_alarm = 0;
    watch(3, cnt, first);
    if (exp_cnt == 1) check({tag, " first cycle"}, c0, 1);
    check({tag, " count"}, c0 + cnt, exp_cnt);
  endtask

  task automatic t_rtc;
    wr(8'h0C, 32'h8000_0000);
    asleep = 1;
    rtc_shot("R7 rtc enabled", 1);
    wr(8'h0C, 32'h0000_0000);
    rtc_shot("R7 rtc disabled", 0);
    wr(8'h0C, 32'h8000_0000);
    asleep = 0;
    rtc_shot("R8 rtc while awake", 0);
  endtask

  task automatic t_hard_reset;
    logic [31:0] d;
    check("R9 clock setting kept through sleep", clk_cfg, 5'h1F);
    rst_n = 0; @(negedge clk); rst_n = 1;
    rd(8'h14, d); check("R9 hard reset clears clock setting", d, 0);
    rd(8'h0C, d); check("R1 mask after hard reset", d, 32'h3);
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset;
    t_regs;
    t_fault;
    t_gpio;
    t_rtc;
    t_hard_reset;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule